// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block gives software control over a bank of general-purpose pins through a small memory-mapped register bus. Each pin can be an input or an output; output levels come from a value register that can be written whole or changed bit by bit through write-one-to-set and write-one-to-clear ports. Input levels are brought through a two-stage synchronizer before anything else looks at them.

Every pin has its own trigger setting, built from three bit-vector registers: one picks edge or level detection, one turns on both-edge detection, and one picks polarity. A detected event is latched in a raw status bit that stays set until software clears it by writing a one. Enable and mask vectors decide which latched events reach the masked status, and one shared interrupt line is raised whenever any masked status bit is set.

Reads are combinational from the address; writes take effect at the clock edge on which the write enable is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (direction register reads all ones, pin_oe all zeros). The output value, enable, mask, trigger registers and raw status all read zero, and irq is low.
- R2: The direction register at offset 0x08 is read/write. A bit of 1 makes that pin an input (pin_oe bit low). A bit of 0 makes it an output (pin_oe bit high).
- R3: The output value register at 0x00 is read/write and drives pin_out. Writing ones to 0x10 sets those output bits, and writing ones to 0x14 clears them. Bits written as zero are left unchanged.
- R4: Reading 0x04 returns the synchronized pin levels. A change on pin_in is visible there after the second rising clock edge and not after the first.
- R5: With trigger-method bit 0 (edge) and both-edges bit 0, a pin with trigger-type bit 0 detects a rising edge and one with bit 1 detects a falling edge. The method, both-edges and type registers sit at 0x34, 0x38 and 0x3C.
- R6: With method 0 and both-edges bit 1, either transition is detected and the trigger-type bit has no effect.
- R7: With method bit 1 (level), trigger-type 0 detects a high level and type 1 detects a low level. While that level holds, the raw status bit is set again on every cycle.
- R8: Raw status (read at 0x24) latches each detected event until a one is written to that bit at 0x30. Zeros written there have no effect. An event in the same cycle as a clear wins, so the bit stays set.
- R9: Masked status (read at 0x28) equals raw AND enable (0x20) AND NOT mask (0x2C). Raw status does not depend on enable or mask.
- R10: irq is high exactly when at least one masked status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | NPINS (32) | Write data |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | NPINS (32) | Read data for bus_addr, combinational |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Output value per pin |
| pin_oe | output | NPINS (32) | Output enable per pin, high for outputs |
| irq | output | 1 | Shared interrupt, OR of masked status |

## Verification
The bench gives each pin one of the eight trigger codes in turn, so every setting is present at once across the bank. It then drives several start and end level patterns and checks the whole raw vector against a value worked out bit by bit. A design that mixed up polarity, let the type bit act in both-edge mode, or missed the both-edge case would show wrong bits on specific pins. Clearing all status while the pins sit still must leave exactly the level-active pins set; a design that let the clear win over a live level would show zeros there. Partial and all-zero clears, the enable and mask gating, and the two-edge latency of the input register are also checked. A synchronizer that is one stage short would show the new input level a cycle too early.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  // Register byte offsets; software decodes these
  localparam logic [7:0] OFF_OUTVAL  = 8'h00;
  localparam logic [7:0] OFF_INVAL   = 8'h04;
  localparam logic [7:0] OFF_DIR     = 8'h08;
  localparam logic [7:0] OFF_SET     = 8'h10;
  localparam logic [7:0] OFF_CLR     = 8'h14;
  localparam logic [7:0] OFF_ENABLE  = 8'h20;
  localparam logic [7:0] OFF_RAW     = 8'h24;
  localparam logic [7:0] OFF_MASKED  = 8'h28;
  localparam logic [7:0] OFF_MASK    = 8'h2C;
  localparam logic [7:0] OFF_ICLR    = 8'h30;
  localparam logic [7:0] OFF_METHOD  = 8'h34;
  localparam logic [7:0] OFF_BOTH    = 8'h38;
  localparam logic [7:0] OFF_TYPE    = 8'h3C;

  // Method bit encoding
  localparam logic MODE_EDGE  = 1'b0;
  localparam logic MODE_LEVEL = 1'b1;

  // One pin's trigger decision from its settings, current and previous level
  function automatic logic pin_trigger(input logic method, input logic both,
                                       input logic ttype, input logic cur,
                                       input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (method == MODE_LEVEL)
      return ttype ? ~cur : cur;
    else if (both)
      return rise | fall;
    else
      return ttype ? fall : rise;
  endfunction

  // Status seen by the shared line for one pin
  function automatic logic pin_masked(input logic raw, input logic en,
                                      input logic msk);
    return raw & en & ~msk;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= stg[STAGES-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] method,
  input  logic [W-1:0] both,
  input  logic [W-1:0] ttype,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = pin_trigger(method[i], both[i], ttype[i], cur[i], prev[i]);
  end
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  input  logic [W-1:0] msk,
  output logic [W-1:0] raw,
  output logic [W-1:0] masked,
  output logic         irq
);
  // A hit in the same cycle as a clear keeps the bit set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr) | hit;
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign masked[i] = pin_masked(raw[i], en[i], msk[i]);
  end

  assign irq = |masked;
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [NPINS-1:0] ALL_ONES = '1;

  logic [NPINS-1:0] out_q, dir_q, en_q, mask_q, meth_q, both_q, type_q;
  logic [NPINS-1:0] sync_q, sync_prev;
  logic [NPINS-1:0] trig_hit, raw_q, masked_w, clr_vec;

  // Write strobes, one per writable location
  logic wr_out, wr_set, wr_clr, wr_dir, wr_en, wr_mask, wr_iclr;
  logic wr_meth, wr_both, wr_type;

  assign wr_out  = bus_we && (bus_addr == AW'(OFF_OUTVAL));
  assign wr_set  = bus_we && (bus_addr == AW'(OFF_SET));
  assign wr_clr  = bus_we && (bus_addr == AW'(OFF_CLR));
  assign wr_dir  = bus_we && (bus_addr == AW'(OFF_DIR));
  assign wr_en   = bus_we && (bus_addr == AW'(OFF_ENABLE));
  assign wr_mask = bus_we && (bus_addr == AW'(OFF_MASK));
  assign wr_iclr = bus_we && (bus_addr == AW'(OFF_ICLR));
  assign wr_meth = bus_we && (bus_addr == AW'(OFF_METHOD));
  assign wr_both = bus_we && (bus_addr == AW'(OFF_BOTH));
  assign wr_type = bus_we && (bus_addr == AW'(OFF_TYPE));

  // Output value: whole write, or bitwise set / clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (wr_out) out_q <= bus_wdata;
    else if (wr_set) out_q <= out_q | bus_wdata;
    else if (wr_clr) out_q <= out_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= ALL_ONES;
      en_q   <= '0;
      mask_q <= '0;
      meth_q <= '0;
      both_q <= '0;
      type_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_en)   en_q   <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_meth) meth_q <= bus_wdata;
      if (wr_both) both_q <= bus_wdata;
      if (wr_type) type_q <= bus_wdata;
    end
  end

  assign clr_vec = wr_iclr ? bus_wdata : '0;
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (pin_in),
    .q      (sync_q),
    .q_prev (sync_prev)
  );

  gpio_trig_detect #(.W(NPINS)) u_detect (
    .method (meth_q),
    .both   (both_q),
    .ttype  (type_q),
    .cur    (sync_q),
    .prev   (sync_prev),
    .hit    (trig_hit)
  );

  gpio_irq_status #(.W(NPINS)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (trig_hit),
    .clr    (clr_vec),
    .en     (en_q),
    .msk    (mask_q),
    .raw    (raw_q),
    .masked (masked_w),
    .irq    (irq)
  );

  // Read mux; write-only locations read as zero
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFF_OUTVAL): bus_rdata = out_q;
      AW'(OFF_INVAL):  bus_rdata = sync_q;
      AW'(OFF_DIR):    bus_rdata = dir_q;
      AW'(OFF_ENABLE): bus_rdata = en_q;
      AW'(OFF_RAW):    bus_rdata = raw_q;
      AW'(OFF_MASKED): bus_rdata = masked_w;
      AW'(OFF_MASK):   bus_rdata = mask_q;
      AW'(OFF_METHOD): bus_rdata = meth_q;
      AW'(OFF_BOTH):   bus_rdata = both_q;
      AW'(OFF_TYPE):   bus_rdata = type_q;
      default:         bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic             irq,
  input logic [NPINS-1:0] trig_hit,
  input logic [NPINS-1:0] raw_q,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] mask_q
);
  // R3: set-port write raises every written-one bit
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFF_SET)) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: clear-port write drops every written-one bit
  a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFF_CLR)) |=>
      ((pin_out & $past(bus_wdata)) == '0));

  // R8: a detected event is latched on the next edge, even under a clear
  a_r8_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_hit) |=> ((raw_q & $past(trig_hit)) == $past(trig_hit)));

  // R8: a clear with no coincident event empties those bits
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~trig_hit)) |=> ((raw_q & $past(clr_vec & ~trig_hit)) == '0));

  // R8: raw bits never appear without a detected event
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(trig_hit)) == '0));

  // R9: nothing enabled, no interrupt
  a_r9_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R9: everything masked, no interrupt
  a_r9_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);

  // R10: the shared line needs a latched event behind it
  a_r10_irq_has_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|raw_q));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .irq       (irq),
  .trig_hit  (trig_hit),
  .raw_q     (raw_q),
  .clr_vec   (clr_vec),
  .en_q      (en_q),
  .mask_q    (mask_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Pin i uses trigger code i%8: bit2 level, bit1 both edges, bit0 type
  function automatic logic [N-1:0] cfg_vec(input int b);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ((i % 8) >> b) & 1;
    return v;
  endfunction

  function automatic logic [N-1:0] exp_raw(input logic [N-1:0] v0, input logic [N-1:0] v1);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int m = i % 8;
      if (m >= 4) r[i] = (m & 1) ? (!v0[i] || !v1[i]) : (v0[i] || v1[i]);
      else        r[i] = (v0[i] != v1[i]) && ((m & 2) != 0 || ((m & 1) ? v0[i] : v1[i]));
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_hold(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int m = i % 8;
      r[i] = (m >= 4) && ((m & 1) ? !v[i] : v[i]);
    end
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d, raw_now, h;
    logic [N-1:0] p0 [6];
    logic [N-1:0] p1 [6];
    p0[0] = 32'h0000_0000; p1[0] = 32'hFFFF_FFFF;
    p0[1] = 32'hFFFF_FFFF; p1[1] = 32'h0000_0000;
    p0[2] = 32'h0000_0000; p1[2] = 32'h0000_0000;
    p0[3] = 32'hFFFF_FFFF; p1[3] = 32'hFFFF_FFFF;
    p0[4] = 32'h00FF_00FF; p1[4] = 32'hFF00_FF00;
    p0[5] = 32'hF0F0_0F0F; p1[5] = 32'h0F0F_F0F0;

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h08, d); chk("R1 dir", d, '1);
    chk("R1 oe", pin_oe, '0);
    chk("R1 out", pin_out, '0);
    rd(8'h24, d); chk("R1 raw", d, '0);
    rd(8'h34, d); chk("R1 method", d, '0);
    chk("R1 irq", {31'd0, irq}, '0);

    // R2 direction
    wr(8'h08, 32'h0000_FFFF);
    chk("R2 oe", pin_oe, 32'hFFFF_0000);
    rd(8'h08, d); chk("R2 readback", d, 32'h0000_FFFF);

    // R3 output value, set and clear ports
    wr(8'h00, 32'h1234_5678); chk("R3 write", pin_out, 32'h1234_5678);
    wr(8'h10, 32'h0F00_0000); chk("R3 set", pin_out, 32'h1F34_5678);
    wr(8'h14, 32'h0000_0078); chk("R3 clear", pin_out, 32'h1F34_5600);
    wr(8'h10, 32'h0);         chk("R3 set zeros", pin_out, 32'h1F34_5600);
    wr(8'h14, 32'h0);         chk("R3 clear zeros", pin_out, 32'h1F34_5600);
    rd(8'h00, d);             chk("R3 readback", d, 32'h1F34_5600);

    // R4 two-edge input latency
    pin_in = 32'hA5A5_5A5A;
    @(negedge clk); rd(8'h04, d); chk("R4 after one edge", d, 32'h0);
    @(negedge clk); rd(8'h04, d); chk("R4 after two edges", d, 32'hA5A5_5A5A);

    // R5 R6 R7 sweep over all eight trigger codes at once
    wr(8'h34, cfg_vec(2));
    wr(8'h38, cfg_vec(1));
    wr(8'h3C, cfg_vec(0));
    rd(8'h38, d); chk("R6 both readback", d, 32'hCCCC_CCCC);
    for (int s = 0; s < 6; s++) begin
      pin_in = p0[s];
      idle(6);
      wr(8'h30, '1);
      pin_in = p1[s];
      idle(6);
      rd(8'h24, d);
      chk($sformatf("R5/R6/R7 sweep %0d raw", s), d, exp_raw(p0[s], p1[s]));
      // R8: clear-all with steady pins leaves only live levels (R7 wins over clear)
      wr(8'h30, '1);
      rd(8'h24, d);
      chk($sformatf("R7/R8 hold after clear %0d", s), d, exp_hold(p1[s]));
    end

    // Build a known raw state: pins low then all high
    pin_in = '0; idle(6); wr(8'h30, '1);
    pin_in = '1; idle(6);
    raw_now = exp_raw('0, '1);
    h = exp_hold('1);

    // R8 zero write to clear has no effect
    wr(8'h30, '0);
    rd(8'h24, d); chk("R8 clear zeros", d, raw_now);
    // R8 partial clear
    wr(8'h30, 32'h0000_FFFF);
    raw_now = (raw_now & 32'hFFFF_0000) | (h & 32'h0000_FFFF);
    rd(8'h24, d); chk("R8 partial clear", d, raw_now);

    // R9 R10 enable and mask gating
    rd(8'h28, d); chk("R9 masked none enabled", d, '0);
    chk("R10 irq idle", {31'd0, irq}, '0);
    wr(8'h20, 32'hFFFF_0000);
    wr(8'h2C, 32'h00FF_0000);
    rd(8'h28, d); chk("R9 masked", d, raw_now & 32'hFF00_0000);
    chk("R10 irq up", {31'd0, irq}, {31'd0, |(raw_now & 32'hFF00_0000)});
    rd(8'h24, d); chk("R9 raw unaffected", d, raw_now);
    wr(8'h2C, '1);
    chk("R10 irq all masked", {31'd0, irq}, '0);
    wr(8'h2C, '0);
    wr(8'h20, 32'h0000_0010);
    rd(8'h28, d); chk("R9 single enable", d, raw_now & 32'h10);
    chk("R10 irq single", {31'd0, irq}, {31'd0, raw_now[4]});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule